// File: doc/BRIEF.md
# Inter-Processor Doorbell Register

This block is a single memory-mapped register through which a host processor signals one remote core. The register holds 28 independent interrupt sources. A host write marks sources as pending only when it also carries a trigger bit. When such a write marks at least one source, the block emits a one-cycle interrupt pulse toward the remote core.

Each pending source stays set until the remote core acknowledges it through a dedicated 28-bit clear port. The host cannot clear a source. When the host reads the register back, it sees which sources the remote core has not yet serviced. A set of the same source always has priority over a clear in the same cycle, so no request is lost.

Top module: `ipi_doorbell`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, every pending bit, `tgt_irq` and `host_rdata` are 0.
- R2: A host write (`host_we`=1) with bit 0 of `host_wdata` equal to 1 makes source n pending for every n where `host_wdata` bit n+4 is 1. The new state shows on `tgt_pending[n]` and on `host_rdata` bit n+4 in the cycle after the write.
- R3: A host write with bit 0 equal to 0 changes no pending bit and produces no pulse, whatever its other bits hold.
- R4: Host writes only set bits. A source whose bit n+4 is written as 0 keeps its previous state, including when the trigger is 1.
- R5: `tgt_ack[n]`=1 clears source n in the following cycle. Acknowledge bits that are 0, and acknowledges of sources that are not pending, change nothing.
- R6: When a trigger write sets source n in the same cycle that `tgt_ack[n]` is 1, source n ends up pending.
- R7: `tgt_irq` is high for exactly the one cycle after each trigger write that has at least one of bits 31..4 set. A trigger write with bits 31..4 all 0 produces no pulse.
- R8: `host_rdata` bits 3..0 always read 0, including after writes of 1 to bits 3..1. Bits 31..4 equal `tgt_pending[27:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| host_we | input | 1 | Host write strobe for the register |
| host_wdata | input | 32 | Host write data: bit 0 is the trigger, bits 31..4 are sources 27..0 |
| host_rdata | output | 32 | Readback: pending sources at bits 31..4, zeros below |
| tgt_ack | input | 28 | Remote-core acknowledge, one bit per source, write-one-to-clear |
| tgt_pending | output | 28 | Pending source vector toward the remote core |
| tgt_irq | output | 1 | One-cycle interrupt pulse toward the remote core |

## Verification
Several write patterns are applied, and each separates one part of the behaviour from the others. Source bits with and without the trigger separate trigger gating from plain storage. A trigger-only write separates pulse generation from the trigger itself. Writes to the reserved bits separate storage from readback packing. Writes of 1 at the two end sources check the n to n+4 mapping at both ends of the field. An acknowledge that hits a source being set in the same cycle, next to one that hits a source not being set, separates the set-over-clear priority from plain clearing. A long stretch of random writes and acknowledges, compared cycle by cycle against a behavioural model, covers combinations that the directed cases miss.

// File: rtl/ipi_doorbell_pkg.sv
package ipi_doorbell_pkg;
  // Default geometry of the doorbell register.
  localparam int unsigned DEF_DATA_W   = 32;
  localparam int unsigned DEF_NUM_SRC  = 28;
  localparam int unsigned DEF_SRC_LSB  = 4;
  localparam int unsigned DEF_TRIG_BIT = 0;

  // Returns 1 when a field of the given width starting at lsb fits in a word.
  function automatic bit field_fits(int unsigned lsb, int unsigned width,
                                    int unsigned word_w);
    return (lsb + width) <= word_w;
  endfunction
endpackage

// File: rtl/ipi_write_decode.sv
module ipi_write_decode
  import ipi_doorbell_pkg::*;
#(
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter int unsigned NUM_SRC  = DEF_NUM_SRC,
  parameter int unsigned SRC_LSB  = DEF_SRC_LSB,
  parameter int unsigned TRIG_BIT = DEF_TRIG_BIT
) (
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wr_word,
  output logic [NUM_SRC-1:0] set_mask,
  output logic               fire
);
  localparam int unsigned SRC_MSB = SRC_LSB + NUM_SRC - 1;

  logic qualified;

  // The trigger bit gates every source bit of the same access.
  always_comb begin
    qualified = wr_en & wr_word[TRIG_BIT];
    set_mask  = qualified ? wr_word[SRC_MSB:SRC_LSB] : '0;
    fire      = |set_mask;
  end
endmodule

// File: rtl/ipi_pending_bank.sv
module ipi_pending_bank
  import ipi_doorbell_pkg::*;
#(
  parameter int unsigned NUM_SRC = DEF_NUM_SRC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set_mask,
  input  logic [NUM_SRC-1:0] clr_mask,
  output logic [NUM_SRC-1:0] pend_q
);
  logic [NUM_SRC-1:0] pend_d;
  logic [NUM_SRC-1:0] pend_en;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cell
    // Next state: a set dominates a clear of the same source.
    always_comb begin
      pend_en[g] = set_mask[g] | clr_mask[g];
      if (set_mask[g]) begin
        pend_d[g] = 1'b1;
      end else if (clr_mask[g]) begin
        pend_d[g] = 1'b0;
      end else begin
        pend_d[g] = pend_q[g];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[g] <= 1'b0;
      end else if (pend_en[g]) begin
        pend_q[g] <= pend_d[g];
      end
    end
  end
endmodule

// File: rtl/ipi_pulse_gen.sv
module ipi_pulse_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic irq_q
);
  logic irq_d;

  always_comb begin
    irq_d = fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end
endmodule

// File: rtl/ipi_read_pack.sv
module ipi_read_pack
  import ipi_doorbell_pkg::*;
#(
  parameter int unsigned DATA_W  = DEF_DATA_W,
  parameter int unsigned NUM_SRC = DEF_NUM_SRC,
  parameter int unsigned SRC_LSB = DEF_SRC_LSB
) (
  input  logic [NUM_SRC-1:0] pend,
  output logic [DATA_W-1:0]  rd_word
);
  localparam int unsigned SRC_MSB = SRC_LSB + NUM_SRC - 1;

  // Each word bit is either a pending source or a constant zero.
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (b >= SRC_LSB && b <= SRC_MSB) begin : g_src
      assign rd_word[b] = pend[b - SRC_LSB];
    end else begin : g_zero
      assign rd_word[b] = 1'b0;
    end
  end
endmodule

// File: rtl/ipi_doorbell.sv
module ipi_doorbell
  import ipi_doorbell_pkg::*;
#(
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter int unsigned NUM_SRC  = DEF_NUM_SRC,
  parameter int unsigned SRC_LSB  = DEF_SRC_LSB,
  parameter int unsigned TRIG_BIT = DEF_TRIG_BIT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_we,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic [DATA_W-1:0]  host_rdata,
  input  logic [NUM_SRC-1:0] tgt_ack,
  output logic [NUM_SRC-1:0] tgt_pending,
  output logic               tgt_irq
);
  localparam bit GEOM_OK = field_fits(SRC_LSB, NUM_SRC, DATA_W) && (TRIG_BIT < SRC_LSB);

  if (!GEOM_OK) begin : g_bad_geom
    initial $error("ipi_doorbell: source field does not fit beside the trigger bit");
  end

  logic [NUM_SRC-1:0] set_mask;
  logic               fire;

  ipi_write_decode #(
    .DATA_W(DATA_W), .NUM_SRC(NUM_SRC), .SRC_LSB(SRC_LSB), .TRIG_BIT(TRIG_BIT)
  ) u_dec (
    .wr_en(host_we), .wr_word(host_wdata), .set_mask(set_mask), .fire(fire)
  );

  ipi_pending_bank #(.NUM_SRC(NUM_SRC)) u_bank (
    .clk(clk), .rst_n(rst_n), .set_mask(set_mask), .clr_mask(tgt_ack),
    .pend_q(tgt_pending)
  );

  ipi_pulse_gen u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(fire), .irq_q(tgt_irq)
  );

  ipi_read_pack #(
    .DATA_W(DATA_W), .NUM_SRC(NUM_SRC), .SRC_LSB(SRC_LSB)
  ) u_rd (
    .pend(tgt_pending), .rd_word(host_rdata)
  );
endmodule

// File: rtl/ipi_doorbell_chk.sv
module ipi_doorbell_chk #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_SRC  = 28,
  parameter int unsigned SRC_LSB  = 4,
  parameter int unsigned TRIG_BIT = 0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               host_we,
  input logic [DATA_W-1:0]  host_wdata,
  input logic [DATA_W-1:0]  host_rdata,
  input logic [NUM_SRC-1:0] tgt_ack,
  input logic [NUM_SRC-1:0] tgt_pending,
  input logic               tgt_irq
);
  localparam int unsigned SRC_MSB = SRC_LSB + NUM_SRC - 1;

  logic               trig_wr;
  logic [NUM_SRC-1:0] wr_src;

  always_comb begin
    trig_wr = host_we & host_wdata[TRIG_BIT];
    wr_src  = host_wdata[SRC_MSB:SRC_LSB];
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (tgt_pending == '0 && !tgt_irq));

  p_trig_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trig_wr |=> ((tgt_pending & $past(wr_src)) == $past(wr_src)));

  p_no_trig_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && !host_wdata[TRIG_BIT] && tgt_ack == '0) |=> $stable(tgt_pending));

  p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_ack != '0 && !trig_wr) |=> ((tgt_pending & $past(tgt_ack)) == '0));

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_wr && (tgt_ack & wr_src) != '0)
      |=> ((tgt_pending & $past(tgt_ack & wr_src)) == $past(tgt_ack & wr_src)));

  p_pulse_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_irq |-> $past(trig_wr && wr_src != '0));

  p_pulse_due_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_wr && wr_src != '0) |=> tgt_irq);

  p_read_map_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rdata[SRC_LSB-1:0] == '0) && (host_rdata[SRC_MSB:SRC_LSB] == tgt_pending));
endmodule

bind ipi_doorbell ipi_doorbell_chk #(
  .DATA_W(DATA_W), .NUM_SRC(NUM_SRC), .SRC_LSB(SRC_LSB), .TRIG_BIT(TRIG_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_wdata(host_wdata),
  .host_rdata(host_rdata), .tgt_ack(tgt_ack), .tgt_pending(tgt_pending),
  .tgt_irq(tgt_irq)
);

// File: tb/ipi_doorbell_test.sv
`timescale 1ns/1ps
module ipi_doorbell_test;
  localparam int NS = 28;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host_we = 1'b0;
  logic [31:0]   host_wdata = '0;
  logic [31:0]   host_rdata;
  logic [NS-1:0] tgt_ack = '0;
  logic [NS-1:0] tgt_pending;
  logic          tgt_irq;

  int    n_checks = 0;
  int    n_fail   = 0;
  string phase    = "R1 reset";
  bit    done     = 1'b0;

  always #10 clk = ~clk;

  ipi_doorbell uut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .tgt_ack(tgt_ack), .tgt_pending(tgt_pending),
    .tgt_irq(tgt_irq)
  );

  // Behavioural reference: one flag per source and one pulse flag.
  bit m_pend [NS];
  bit m_irq;

  always @(posedge clk or negedge rst_n) begin : ref_model
    bit any;
    if (!rst_n) begin
      for (int n = 0; n < NS; n++) m_pend[n] <= 1'b0;
      m_irq <= 1'b0;
    end else begin
      any = 1'b0;
      for (int n = 0; n < NS; n++) begin
        if (host_we && host_wdata[0] && host_wdata[n+4]) begin
          m_pend[n] <= 1'b1;
          any = 1'b1;
        end else if (tgt_ack[n]) begin
          m_pend[n] <= 1'b0;
        end
      end
      m_irq <= any;
    end
  end

  function automatic logic [31:0] model_word();
    logic [31:0] w = '0;
    for (int n = 0; n < NS; n++) w[n+4] = m_pend[n];
    return w;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check({phase, " model rdata (R8)"}, host_rdata, model_word());
      check({phase, " model pending"}, {4'b0, tgt_pending}, model_word() >> 4);
      check({phase, " model irq (R7)"}, {31'b0, tgt_irq}, {31'b0, m_irq});
    end
  end

  // Apply one cycle of stimulus, then return to idle at the next negedge.
  task automatic cyc(logic we, logic [31:0] wd, logic [NS-1:0] ack);
    @(negedge clk);
    host_we = we; host_wdata = wd; tgt_ack = ack;
    @(negedge clk);
    host_we = 1'b0; host_wdata = '0; tgt_ack = '0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin : watchdog
    #(200000 * 20);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin : stimulus
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 rdata in reset", host_rdata, 32'h0);
    check("R1 irq in reset", {31'b0, tgt_irq}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 rdata after release", host_rdata, 32'h0);

    // R2 / R7: trigger write sets source 0 and pulses once
    phase = "R2";
    @(negedge clk); host_we = 1'b1; host_wdata = 32'h0000_0011;
    @(negedge clk); host_we = 1'b0; host_wdata = '0;
    check("R2 source0 pending", host_rdata, 32'h0000_0010);
    check("R7 pulse high", {31'b0, tgt_irq}, 32'h1);
    @(negedge clk);
    check("R7 pulse one cycle", {31'b0, tgt_irq}, 32'h0);

    // R3: no trigger, nothing changes
    phase = "R3";
    cyc(1'b1, 32'hFFFF_FFF0, '0);
    check("R3 untriggered write ignored", host_rdata, 32'h0000_0010);
    check("R3 no pulse", {31'b0, tgt_irq}, 32'h0);

    // R7 / R4: trigger with no sources
    phase = "R4";
    cyc(1'b1, 32'h0000_0001, '0);
    check("R7 empty trigger no pulse", {31'b0, tgt_irq}, 32'h0);
    check("R4 zero bits keep state", host_rdata, 32'h0000_0010);

    // R2: top source mapping
    phase = "R2 top";
    cyc(1'b1, 32'h8000_0001, '0);
    check("R2 source27 pending", host_rdata, 32'h8000_0010);
    check("R2 pending vector", {4'b0, tgt_pending}, 32'h0800_0001);

    // R8: reserved bits
    phase = "R8";
    cyc(1'b1, 32'h0000_000F, '0);
    check("R8 reserved read zero", host_rdata, 32'h8000_0010);

    // R5: acknowledge clears, stray acknowledge ignored
    phase = "R5";
    cyc(1'b0, '0, 28'h000_0001);
    check("R5 ack clears source0", host_rdata, 32'h8000_0000);
    cyc(1'b0, '0, 28'h000_0F00);
    check("R5 ack of idle sources", host_rdata, 32'h8000_0000);

    // R6: set wins; unrelated ack in same cycle still clears
    phase = "R6";
    cyc(1'b1, 32'h0000_0201, 28'h800_0020);
    check("R6 set beats ack", host_rdata, 32'h0000_0200);

    // R2/R5 random mix checked by the model every cycle
    phase = "R2 R5 random";
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      host_we    = ($urandom_range(0, 2) != 0);
      host_wdata = $urandom() & ($urandom_range(0, 3) == 0 ? 32'h0000_1111 : 32'hFFFF_FFFF);
      tgt_ack    = NS'($urandom() & $urandom());
    end
    @(negedge clk); host_we = 1'b0; host_wdata = '0; tgt_ack = '0;

    // R1: reset in the middle of operation
    phase = "R1 midrun";
    cyc(1'b1, 32'hFFFF_FFF1, '0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset clears pending", host_rdata, 32'h0);
    check("R1 reset clears irq", {31'b0, tgt_irq}, 32'h0);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule